// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block models the controller that walks a programmable device through its configuration life cycle. A host talks to it through a plain 32-bit register port. Through that port it reads the mode strap and the current phase, sets control bits that pull the device into reset and open the data path, pushes configuration words, and loads a dummy-clock counter whose completion is flagged in a status bit.

The phase advances from an unconfigured state to reset, configuration, initialisation and user operation. Each step is taken only on a specific event: an edge of the reset-pull control bit, the arrival of a programmed number of data words, or a count of dummy clocks. From the strap the block derives the configuration data width and the clock-to-data ratio, and the ratio decode depends on the width. A small set of sticky event flags lets the host see phase entries, and a mask write clears them.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset the phase field (STATUS bits [2:0]) reads 0, CTRL bits [3:0] read 0x1 (chip enable deasserted), the monitor word, the dummy-clock done bit and the pending-event word all read 0.
- R2: CTRL bit 4 shows the configured data width: 1 for 32-bit when strap bit 3 is 1, and 0 for 16-bit when it is 0.
- R3: CTRL bits [6:5] hold the ratio code (0 = x1, 1 = x2, 2 = x4, 3 = x8). With a 32-bit width, strap bits [1:0] of 0, 1 and 2 give codes 0, 2 and 3. With a 16-bit width they give 0, 1 and 2. Strap value 3 gives code 0.
- R4: CTRL uses these bits: bit0 chip-enable-low, bit1 drive enable, bit2 reset pull, bit3 data enable. A rising edge of the pull bit, taken while drive is 1 and chip-enable-low is 0, moves the phase to 1 (reset) from any phase. A later falling edge moves it to 2 (configuration) and restarts the word count. A pull edge without those enables is ignored.
- R5: A write to the DATA register (address 7) counts as a configuration word only in phase 2 with data enable, drive enable and chip enable all active. Other data writes change nothing.
- R6: MON bit 1 (config done) sets once CFG_WORDS words have been accepted. MON bit 0 (status OK) is 1 in phases 2, 3 and 4. Both bits are 0 in phases 0 and 1.
- R7: Writing N to the dummy-count register (address 2) produces N dummy clocks and then sets DSTAT bit 0. Writing 1 to DSTAT bit 0 clears it.
- R8: After config done, INIT_TICKS dummy clocks (default 4) move the phase to 3. A further USER_TICKS clocks (default 0x5000) move it to 4. The phase does not change one clock earlier.
- R9: The pending word (address 6) latches four events: bit0 entry into phase 1, bit1 entry into phase 2, bit2 config done rising, bit3 entry into phase 4. Writing a mask to EOI (address 5) clears the masked bits, and 0xFFF clears all of them.
- R10: Dropping drive enable or raising chip-enable-low in phase 2 or 3 returns the phase to 1. The same change in phase 4 leaves the phase at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_strap | input | 4 | Mode-select strap: bit3 width, bits[1:0] ratio |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| dclk_tick | output | 1 | One pulse per generated dummy clock |
| phase | output | 3 | Current phase code |

## Verification
The bench goes after the ratio decode in both widths. A decoder that ignored the width would report x2 where x4 is due. It stops the dummy counts one clock short of each phase threshold, which exposes a counter that is off by one and changes phase too early or too late. Data writes with data enable clear must leave config done low, so a design that counted them would raise it early. The bench also drops drive enable in configuration and in user phase, so a design that treated both alike would fail one of the two checks.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

   typedef enum logic [2:0] {
      PH_OFF  = 3'd0,
      PH_RST  = 3'd1,
      PH_CFG  = 3'd2,
      PH_INIT = 3'd3,
      PH_USER = 3'd4
   } phase_t;

   typedef enum logic [2:0] {
      RA_STATUS = 3'd0,
      RA_CTRL   = 3'd1,
      RA_DCNT   = 3'd2,
      RA_DSTAT  = 3'd3,
      RA_MON    = 3'd4,
      RA_EOI    = 3'd5,
      RA_PEND   = 3'd6,
      RA_DATA   = 3'd7
   } reg_addr_t;

   // writable control bits, packed so bit 0 is chip_en_n
   typedef struct packed {
      logic data_en;
      logic pull;
      logic drive_en;
      logic chip_en_n;
   } ctrl_t;

   localparam logic [1:0] RATIO_X1 = 2'd0;
   localparam logic [1:0] RATIO_X2 = 2'd1;
   localparam logic [1:0] RATIO_X4 = 2'd2;
   localparam logic [1:0] RATIO_X8 = 2'd3;

   localparam int EVT_W = 4;

endpackage

// File: rtl/cfg_strap_decode.sv
module cfg_strap_decode
   import cfg_seq_pkg::*;
(
   input  logic       wide_sel,
   input  logic [1:0] rate_sel,
   output logic       width32,
   output logic [1:0] ratio
);

   always_comb begin
      width32 = wide_sel;
      ratio   = RATIO_X1;
      if (wide_sel) begin
         case (rate_sel)
            2'd1:    ratio = RATIO_X4;
            2'd2:    ratio = RATIO_X8;
            default: ratio = RATIO_X1;
         endcase
      end else begin
         case (rate_sel)
            2'd1:    ratio = RATIO_X2;
            2'd2:    ratio = RATIO_X4;
            default: ratio = RATIO_X1;
         endcase
      end
   end

endmodule

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr_done,
   output logic             tick,
   output logic             done
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("cfg_dclk_gen: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] remain;
   logic             busy;
   logic             finish;

   assign tick   = busy && (remain != '0);
   assign finish = busy && !load && (remain == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         if (load) begin
            remain <= load_val;
            busy   <= 1'b1;
         end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
         end
         if (finish)        done <= 1'b1;
         else if (clr_done) done <= 1'b0;
      end
   end

   // R7: the done flag only rises at the end of a counting run
   a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R7: a clear with no run in progress leaves done low
   a_r7_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_done) && !$past(busy)) |-> !done);

endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
   import cfg_seq_pkg::*;
#(
   parameter int CFG_WORDS  = 16,
   parameter int INIT_TICKS = 4,
   parameter int USER_TICKS = 32'h5000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  ctrl_t  ctrl,
   input  logic   data_wr,
   input  logic   tick,
   output phase_t phase,
   output logic   cfg_done
);

   localparam int WCNT_W = $clog2(CFG_WORDS + 1);
   localparam int TMAX   = (USER_TICKS > INIT_TICKS) ? USER_TICKS : INIT_TICKS;
   localparam int TCNT_W = $clog2(TMAX + 1);

   generate
      if (CFG_WORDS < 1) begin : g_bad_words
         $error("cfg_phase_fsm: CFG_WORDS must be at least 1");
      end
      if (INIT_TICKS < 1 || USER_TICKS < 1) begin : g_bad_ticks
         $error("cfg_phase_fsm: tick thresholds must be at least 1");
      end
   endgenerate

   logic              pull_q;
   logic              pull_rise, pull_fall, enabled;
   logic [WCNT_W-1:0] word_cnt;
   logic [TCNT_W-1:0] tick_cnt;
   logic              accept, last_word, counting, tick_hit;
   phase_t            phase_nx;

   assign enabled   = ctrl.drive_en && !ctrl.chip_en_n;
   assign pull_rise = ctrl.pull && !pull_q;
   assign pull_fall = !ctrl.pull && pull_q;

   assign accept    = data_wr && ctrl.data_en && enabled && (phase == PH_CFG)
                      && (word_cnt < WCNT_W'(CFG_WORDS));
   assign last_word = accept && (word_cnt == WCNT_W'(CFG_WORDS - 1));

   assign counting  = ((phase == PH_CFG) && cfg_done) || (phase == PH_INIT);
   always_comb begin
      tick_hit = 1'b0;
      if (tick && counting) begin
         if (phase == PH_CFG) tick_hit = (tick_cnt == TCNT_W'(INIT_TICKS - 1));
         else                 tick_hit = (tick_cnt == TCNT_W'(USER_TICKS - 1));
      end
   end

   always_comb begin
      phase_nx = phase;
      if (pull_rise && enabled) begin
         phase_nx = PH_RST;
      end else begin
         case (phase)
            PH_RST:  if (pull_fall && enabled) phase_nx = PH_CFG;
            PH_CFG:  if (!enabled) phase_nx = PH_RST;
                     else if (tick_hit) phase_nx = PH_INIT;
            PH_INIT: if (!enabled) phase_nx = PH_RST;
                     else if (tick_hit) phase_nx = PH_USER;
            default: phase_nx = phase;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_OFF;
         pull_q   <= 1'b0;
         word_cnt <= '0;
         tick_cnt <= '0;
         cfg_done <= 1'b0;
      end else begin
         phase  <= phase_nx;
         pull_q <= ctrl.pull;
         if (phase_nx != phase) begin
            tick_cnt <= '0;
         end else if (tick && counting) begin
            tick_cnt <= tick_cnt + 1'b1;
         end
         if (phase_nx == PH_RST || (phase_nx == PH_CFG && phase != PH_CFG)) begin
            word_cnt <= '0;
            cfg_done <= 1'b0;
         end else begin
            if (accept)    word_cnt <= word_cnt + 1'b1;
            if (last_word) cfg_done <= 1'b1;
         end
      end
   end

   // R4: configuration is only reachable from the reset phase
   a_r4_cfg_from_rst: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CFG && $past(phase) != PH_CFG) |-> $past(phase) == PH_RST);

   // R6: the word counter never runs past the programmed length
   a_r6_words_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      word_cnt <= WCNT_W'(CFG_WORDS));

   // R8: initialisation needs config done beforehand
   a_r8_init_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INIT && $past(phase) == PH_CFG) |-> $past(cfg_done));

   // R8: user phase is entered only from initialisation
   a_r8_user_from_init: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_USER && $past(phase) != PH_USER) |-> $past(phase) == PH_INIT);

   // R10: leaving configuration or init for reset needs lost enables or a pull
   a_r10_drop_to_rst: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RST && ($past(phase) == PH_CFG || $past(phase) == PH_INIT))
      |-> (!$past(enabled) || $past(pull_rise)));

   a_r1_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= PH_USER);

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
   import cfg_seq_pkg::*;
#(
   parameter int CFG_WORDS  = 16,
   parameter int INIT_TICKS = 4,
   parameter int USER_TICKS = 32'h5000,
   parameter int DCLK_W     = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  mode_strap,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        reg_rvalid,
   output logic        dclk_tick,
   output logic [2:0]  phase
);

   generate
      if (DCLK_W > 32) begin : g_bad_dclk
         $error("cfg_seq_top: DCLK_W cannot exceed the 32-bit port");
      end
   endgenerate

   ctrl_t            ctrl;
   logic             width32;
   logic [1:0]       ratio;
   logic             dclk_done;
   logic             cfg_done;
   logic             status_ok;
   phase_t           ph, ph_q;
   logic             done_q;
   logic [EVT_W-1:0] evt, pend;
   logic             wr_ctrl, wr_dcnt, wr_dstat, wr_eoi, wr_data;

   assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
   assign wr_dcnt  = reg_wr && (reg_addr == RA_DCNT);
   assign wr_dstat = reg_wr && (reg_addr == RA_DSTAT);
   assign wr_eoi   = reg_wr && (reg_addr == RA_EOI);
   assign wr_data  = reg_wr && (reg_addr == RA_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl <= 4'b0001;
      else if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[3:0]);
   end

   cfg_strap_decode u_strap (
      .wide_sel (mode_strap[3]),
      .rate_sel (mode_strap[1:0]),
      .width32  (width32),
      .ratio    (ratio)
   );

   cfg_dclk_gen #(.CNT_W(DCLK_W)) u_dclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_dcnt),
      .load_val (reg_wdata[DCLK_W-1:0]),
      .clr_done (wr_dstat && reg_wdata[0]),
      .tick     (dclk_tick),
      .done     (dclk_done)
   );

   cfg_phase_fsm #(
      .CFG_WORDS  (CFG_WORDS),
      .INIT_TICKS (INIT_TICKS),
      .USER_TICKS (USER_TICKS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl     (ctrl),
      .data_wr  (wr_data),
      .tick     (dclk_tick),
      .phase    (ph),
      .cfg_done (cfg_done)
   );

   assign phase     = ph;
   assign status_ok = (ph == PH_CFG) || (ph == PH_INIT) || (ph == PH_USER);

   // event sources, one per pending bit
   assign evt[0] = (ph == PH_RST)  && (ph_q != PH_RST);
   assign evt[1] = (ph == PH_CFG)  && (ph_q != PH_CFG);
   assign evt[2] = cfg_done && !done_q;
   assign evt[3] = (ph == PH_USER) && (ph_q != PH_USER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_OFF;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph;
         done_q <= cfg_done;
      end
   end

   generate
      for (genvar i = 0; i < EVT_W; i++) begin : g_pend
         always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else if (evt[i]) pend[i] <= 1'b1;
            else if (wr_eoi && reg_wdata[i]) pend[i] <= 1'b0;
         end

         // R9: a pending flag falls only under an EOI mask bit
         a_r9_clear_by_eoi: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[i]) |-> ($past(wr_eoi) && $past(reg_wdata[i])));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) begin
            case (reg_addr)
               RA_STATUS: reg_rdata <= {24'd0, mode_strap, 1'b0, ph};
               RA_CTRL:   reg_rdata <= {25'd0, ratio, width32, ctrl};
               RA_DSTAT:  reg_rdata <= {31'd0, dclk_done};
               RA_MON:    reg_rdata <= {30'd0, cfg_done, status_ok};
               RA_PEND:   reg_rdata <= {{(32-EVT_W){1'b0}}, pend};
               default:   reg_rdata <= '0;
            endcase
         end
      end
   end

   // R3: the x8 ratio only exists in the 32-bit width
   a_r3_x8_needs_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rvalid && $past(reg_addr) == RA_CTRL && reg_rdata[6:5] == RATIO_X8)
      |-> reg_rdata[4]);

   // R6: config done is never shown in the idle or reset phases
   a_r6_done_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> status_ok);

endmodule

// File: tb/test_cfg_seq_top.sv
module test_cfg_seq_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  mode_strap;
   logic        reg_wr, reg_rd;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        reg_rvalid;
   logic        dclk_tick;
   logic [2:0]  phase;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   typedef struct {
      logic [31:0] mask;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   cfg_seq_top i_cfg_seq_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_strap (mode_strap),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .dclk_tick  (dclk_tick),
      .phase      (phase)
   );

   // monitor: pop expected item for each returned read
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL unexpected read data %h", reg_rdata);
         end else begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ((reg_rdata & it.mask) !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag,
                        reg_rdata & it.mask, it.exp);
            end
         end
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic chk(logic [2:0] a, logic [31:0] m, logic [31:0] e, string t);
      item_t it;
      it.mask = m; it.exp = e; it.tag = t;
      sb.push_back(it);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_addr = '0; reg_wdata = '0; mode_strap = 4'b1000;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk(3'd0, 32'h7, 32'h0, "R1 phase after reset");
      chk(3'd1, 32'hF, 32'h1, "R1 ctrl after reset");
      chk(3'd4, 32'h3, 32'h0, "R1 monitor after reset");
      chk(3'd3, 32'h1, 32'h0, "R1 dclk done after reset");
      chk(3'd6, 32'hF, 32'h0, "R1 pending after reset");

      // R2 / R3 strap decode
      mode_strap = 4'b1000; chk(3'd1, 32'h70, 32'h10, "R2 R3 wide x1");
      mode_strap = 4'b1001; chk(3'd1, 32'h70, 32'h50, "R3 wide strap1 x4");
      mode_strap = 4'b1010; chk(3'd1, 32'h70, 32'h70, "R3 wide strap2 x8");
      mode_strap = 4'b1011; chk(3'd1, 32'h70, 32'h10, "R3 wide strap3 x1");
      mode_strap = 4'b0000; chk(3'd1, 32'h70, 32'h00, "R2 R3 narrow x1");
      mode_strap = 4'b0001; chk(3'd1, 32'h70, 32'h20, "R3 narrow strap1 x2");
      mode_strap = 4'b0010; chk(3'd1, 32'h70, 32'h40, "R3 narrow strap2 x4");
      mode_strap = 4'b1001;

      // R4 pull without enables is ignored
      wr(3'd1, 32'h5);   // pull with chip disabled, no drive
      idle(2);
      chk(3'd0, 32'h7, 32'h0, "R4 pull without enables ignored");
      wr(3'd1, 32'h2);   // drive on, chip enabled, pull low
      idle(2);
      chk(3'd0, 32'h7, 32'h0, "R4 pull fall without reset phase");
      wr(3'd1, 32'h6);
      idle(2);
      chk(3'd0, 32'h7, 32'h1, "R4 pull rise enters reset");
      chk(3'd4, 32'h3, 32'h0, "R6 monitor low in reset");
      wr(3'd1, 32'h2);
      idle(2);
      chk(3'd0, 32'h7, 32'h2, "R4 pull fall enters config");
      chk(3'd4, 32'h3, 32'h1, "R6 status ok in config");

      // R5 data writes ignored without data enable
      for (int i = 0; i < 20; i++) wr(3'd7, 32'hA5A5_0000 + i);
      chk(3'd4, 32'h3, 32'h1, "R5 data without enable ignored");
      wr(3'd1, 32'hA);
      for (int i = 0; i < 15; i++) wr(3'd7, i);
      chk(3'd4, 32'h3, 32'h1, "R6 done low one word short");
      // R8 ticks before done do not count
      wr(3'd2, 32'd8);
      idle(14);
      chk(3'd0, 32'h7, 32'h2, "R8 ticks before done ignored");
      wr(3'd3, 32'h1);
      wr(3'd7, 32'hFF);
      idle(1);
      chk(3'd4, 32'h3, 32'h3, "R6 done after last word");

      // R7 dummy clock count and done flag
      wr(3'd2, 32'd3);
      idle(8);
      chk(3'd3, 32'h1, 32'h1, "R7 done after run");
      chk(3'd0, 32'h7, 32'h2, "R8 three ticks stay in config");
      wr(3'd3, 32'h1);
      chk(3'd3, 32'h1, 32'h0, "R7 write one clears done");
      wr(3'd2, 32'd1);
      idle(5);
      chk(3'd0, 32'h7, 32'h3, "R8 fourth tick enters init");
      wr(3'd3, 32'h1);
      wr(3'd2, 32'h4FFF);
      idle(20500);
      chk(3'd3, 32'h1, 32'h1, "R7 long run done");
      chk(3'd0, 32'h7, 32'h3, "R8 one tick short of user");
      wr(3'd3, 32'h1);
      wr(3'd2, 32'd1);
      idle(5);
      chk(3'd0, 32'h7, 32'h4, "R8 enters user phase");
      chk(3'd4, 32'h3, 32'h3, "R6 monitor in user phase");

      // R9 pending events and EOI
      chk(3'd6, 32'hF, 32'hF, "R9 all events pending");
      wr(3'd5, 32'h3);
      chk(3'd6, 32'hF, 32'hC, "R9 partial EOI mask");
      wr(3'd5, 32'hFFF);
      chk(3'd6, 32'hF, 32'h0, "R9 full EOI clear");

      // R10 dropping drive in user phase has no effect
      wr(3'd1, 32'h0);
      idle(2);
      chk(3'd0, 32'h7, 32'h4, "R10 user phase keeps on drive loss");
      wr(3'd1, 32'h2);
      wr(3'd1, 32'h6);
      wr(3'd1, 32'h2);
      idle(2);
      chk(3'd0, 32'h7, 32'h2, "R4 re-entry into config");
      chk(3'd4, 32'h3, 32'h1, "R4 word count restarted");
      wr(3'd1, 32'h0);
      idle(2);
      chk(3'd0, 32'h7, 32'h1, "R10 drive loss in config to reset");
      chk(3'd6, 32'hF, 32'h3, "R9 re-entry events latched");

      idle(4);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard left %0d items", sb.size());
      end
      finish_run();
   end

endmodule